// File: doc/BRIEF.md
# Serial Port Control and Status Register File

This block is the software-visible register set of a simple serial port. A 32-bit word-wide slave port with separate read and write strobes gives access to a 1 KiB window. The window holds interrupt state, enable and test registers, a control register, a status register, a receive-data holding register, a transmit-data entry point, a queue-control register and three plain storage registers. The block owns the four level-sensitive interrupt lines of the port.

The line logic around it reports events on single-cycle pulses: a transmit-watermark crossing, a transmit queue running dry and a receive overflow. The receiver delivers each incoming byte on a strobe, together with its current fill count. In the other direction the block hands every byte written by software to the transmit queue on a one-cycle push pulse. It also raises a one-cycle flush pulse when software asks for the transmit queue to be emptied.

Word index map (byte offset = 4 x index): 0 control, 1 status, 2 receive data, 3 transmit data, 4 interrupt state, 5 interrupt enable, 6 interrupt test, 7 queue control, 8 queue status, 9 override storage, 10 line value, 11 timeout storage. Interrupt bit positions: 0 transmit watermark, 1 receive watermark, 2 transmit empty, 3 receive overflow.

Top module: `serial_csr`

## Requirements
- R1: Each interrupt output is 1 exactly when both its interrupt-state bit and its interrupt-enable bit are 1. Bits: 0 transmit watermark, 1 receive watermark, 2 transmit empty, 3 receive overflow.
- R2: A write to the interrupt-state register (index 4) clears each state bit written as 1 and leaves every bit written as 0 unchanged.
- R3: A write to the interrupt-test register (index 6) sets each state bit written as 1. A read of index 6 returns zero.
- R4: After reset every register reads zero, except status, which reads 0x3C. The interrupt outputs, read data, push pulse and flush pulse are all 0.
- R5: On the received-byte strobe the byte is latched into the receive-data register (index 2, bits 7:0). Status bit 4 (receiver idle) and bit 5 (receive empty) clear.
- R6: On the received-byte strobe, when the fill count is strictly greater than the receive threshold in queue-control bits 4:2, the receive-watermark state bit sets.
- R7: A read of the receive-data register while control bit 1 (receive enable) is 1 returns the byte and then sets status bits 4 and 5. With control bit 1 at 0 the read leaves the status unchanged. A byte strobe in the same cycle takes priority and clears the bits.
- R8: Writes to status, receive data, queue status (index 8) and line value (index 10) have no effect. Reads of transmit data and line value return zero. Queue status reads back the receiver fill count in its low bits.
- R9: An access whose byte address is not a multiple of 4, or whose index is above 11, writes nothing and reads zero.
- R10: A write to transmit data (index 3) gives tx_push high for one cycle on the next edge, with tx_byte equal to the written bits 7:0. It clears status bits 2 and 3 (transmit empty, transmit idle). A transmit-empty event sets them again; a write in the same cycle as that event wins.
- R11: An event input in the same cycle as a write-one-to-clear of its state bit wins, and the bit stays set.
- R12: Read data appears on bus_rdata one cycle after the read strobe and is zero in every cycle that follows no read.
- R13: A write to queue control with bit 1 set gives tx_flush high for one cycle. Bits 1:0 read back as zero. Bits 6:2 are stored.
- R14: Control (index 0), override (index 9) and timeout (index 11) store all 32 written bits and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_tx_wmark | input | 1 | Transmit watermark event pulse |
| ev_tx_empty | input | 1 | Transmit queue empty event pulse |
| ev_rx_ovf | input | 1 | Receive overflow event pulse |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_count | input | 5 | Receiver fill count |
| tx_push | output | 1 | Push pulse towards the transmit queue |
| tx_byte | output | 8 | Byte pushed |
| tx_flush | output | 1 | Transmit queue flush pulse |
| irq_tx_wmark | output | 1 | Transmit watermark interrupt |
| irq_rx_wmark | output | 1 | Receive watermark interrupt |
| irq_tx_empty | output | 1 | Transmit empty interrupt |
| irq_rx_ovf | output | 1 | Receive overflow interrupt |

## Verification
Every result of this block is due exactly one clock edge after the cycle that caused it. Read data follows its strobe by one edge. The interrupt lines, push pulse and flush pulse change on the edge that samples the event or write. Status side effects become visible to a read issued in the following cycle. The bench therefore drives each stimulus at a falling edge, lets one rising edge pass, and compares every output at the next falling edge with a model advanced once per edge, before any new stimulus is applied.

// File: rtl/serial_csr_pkg.sv
// Shared constants of the serial-port register file: word indices,
// interrupt bit positions, status bit positions and field locations.
package serial_csr_pkg;

    localparam int unsigned NUM_IRQ  = 4;
    localparam int unsigned NUM_REGS = 12;

    // Word indices (byte offset = 4 * index)
    localparam int unsigned IDX_CTRL    = 0;
    localparam int unsigned IDX_STATUS  = 1;
    localparam int unsigned IDX_RDATA   = 2;
    localparam int unsigned IDX_WDATA   = 3;
    localparam int unsigned IDX_ISTATE  = 4;
    localparam int unsigned IDX_IEN     = 5;
    localparam int unsigned IDX_ITEST   = 6;
    localparam int unsigned IDX_FCTRL   = 7;
    localparam int unsigned IDX_FSTAT   = 8;
    localparam int unsigned IDX_OVRD    = 9;
    localparam int unsigned IDX_LINEVAL = 10;
    localparam int unsigned IDX_TMO     = 11;

    // Interrupt bit positions
    localparam int unsigned IRQ_TX_WMARK = 0;
    localparam int unsigned IRQ_RX_WMARK = 1;
    localparam int unsigned IRQ_TX_EMPTY = 2;
    localparam int unsigned IRQ_RX_OVF   = 3;

    // Status bit positions and reset value
    localparam int unsigned STATUS_W     = 6;
    localparam int unsigned ST_TX_FULL   = 0;
    localparam int unsigned ST_RX_FULL   = 1;
    localparam int unsigned ST_TX_EMPTY  = 2;
    localparam int unsigned ST_TX_IDLE   = 3;
    localparam int unsigned ST_RX_IDLE   = 4;
    localparam int unsigned ST_RX_EMPTY  = 5;
    localparam logic [STATUS_W-1:0] STATUS_RST = 6'h3C;

    // Control and queue-control fields
    localparam int unsigned CTRL_RX_EN_BIT  = 1;
    localparam int unsigned FC_TX_FLUSH_BIT = 1;
    localparam int unsigned FC_KEEP_LO      = 2;
    localparam int unsigned FC_KEEP_HI      = 6;
    localparam int unsigned FC_RXT_LO       = 2;
    localparam int unsigned FC_RXT_W        = 3;

endpackage

// File: rtl/serial_csr_decode.sv
// Address decoder: turns a byte address and the two strobes into one-hot
// read and write selects, one per word register.
// Assumes: only word-aligned addresses hit a register; all others select nothing.
module serial_csr_decode #(
    parameter int unsigned AW   = 10,
    parameter int unsigned NREG = 12
) (
    input  logic [AW-1:0]   addr,
    input  logic            rd_en,
    input  logic            wr_en,
    output logic [NREG-1:0] rd_sel,
    output logic [NREG-1:0] wr_sel
);
    localparam int unsigned IW = AW - 2;

    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    // One comparator per register index
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        localparam logic [IW-1:0] IDX = IW'(i);
        assign rd_sel[i] = rd_en && aligned && (addr[AW-1:2] == IDX);
        assign wr_sel[i] = wr_en && aligned && (addr[AW-1:2] == IDX);
    end
endmodule

// File: rtl/serial_csr_irq.sv
// Interrupt core: per-bit state (event or test sets, write-one clears,
// set wins), per-bit enable, and level outputs state AND enable.
// Assumes: clear and test writes never arrive in the same cycle.
module serial_csr_irq #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic         test_we,
    input  logic [N-1:0] wmask,
    input  logic [N-1:0] events,
    output logic [N-1:0] state_q,
    output logic [N-1:0] enable_q,
    output logic [N-1:0] irq
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        // State bit: set has priority over write-one-to-clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[b] <= 1'b0;
            end else if (events[b] || (test_we && wmask[b])) begin
                state_q[b] <= 1'b1;
            end else if (clr_we && wmask[b]) begin
                state_q[b] <= 1'b0;
            end
        end

        // Enable bit: plain storage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                enable_q[b] <= 1'b0;
            end else if (en_we) begin
                enable_q[b] <= wmask[b];
            end
        end

        assign irq[b] = state_q[b] & enable_q[b];
    end
endmodule

// File: rtl/serial_csr_rx.sv
// Receive holding register with its two status flags (receiver idle,
// receive empty). A byte strobe latches the byte and clears both flags; a
// consuming read sets them again. The byte strobe wins when both coincide.
module serial_csr_rx #(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [BW-1:0] rx_byte,
    input  logic          rd_pop,
    output logic [BW-1:0] byte_q,
    output logic          rx_idle_q,
    output logic          rx_empty_q
);
    // Holding register for the last received byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (rx_valid) begin
            byte_q <= rx_byte;
        end
    end

    // Idle and empty flags, both reset to 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_idle_q  <= 1'b1;
            rx_empty_q <= 1'b1;
        end else if (rx_valid) begin
            rx_idle_q  <= 1'b0;
            rx_empty_q <= 1'b0;
        end else if (rd_pop) begin
            rx_idle_q  <= 1'b1;
            rx_empty_q <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_csr.sv
// Serial-port register file top. Decodes the word slave port, holds the
// control, queue-control and storage registers, tracks transmit-empty
// status, issues push/flush pulses, and returns registered read data one
// cycle after each read strobe (zero when no read was made).
// Assumes: DW >= 32 and BW <= DW; line timing lives outside this block.
module serial_csr
    import serial_csr_pkg::*;
#(
    parameter int unsigned AW    = 10,
    parameter int unsigned DW    = 32,
    parameter int unsigned BW    = 8,
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_re,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             ev_tx_wmark,
    input  logic             ev_tx_empty,
    input  logic             ev_rx_ovf,
    input  logic             rx_valid,
    input  logic [BW-1:0]    rx_byte,
    input  logic [CNT_W-1:0] rx_count,
    output logic             tx_push,
    output logic [BW-1:0]    tx_byte,
    output logic             tx_flush,
    output logic             irq_tx_wmark,
    output logic             irq_rx_wmark,
    output logic             irq_tx_empty,
    output logic             irq_rx_ovf
);
    localparam int unsigned FC_W = FC_KEEP_HI - FC_KEEP_LO + 1;

    logic [NUM_REGS-1:0] rd_sel;
    logic [NUM_REGS-1:0] wr_sel;
    logic [DW-1:0]       ctrl_q;
    logic [DW-1:0]       ovrd_q;
    logic [DW-1:0]       tmo_q;
    logic [FC_W-1:0]     fc_q;
    logic                tx_drained_q;
    logic                tx_push_q;
    logic [BW-1:0]       tx_byte_q;
    logic                tx_flush_q;
    logic [DW-1:0]       rdata_q;
    logic [DW-1:0]       rd_mux;
    logic [NUM_IRQ-1:0]  irq_events;
    logic [NUM_IRQ-1:0]  irq_state;
    logic [NUM_IRQ-1:0]  irq_en;
    logic [NUM_IRQ-1:0]  irq_vec;
    logic [BW-1:0]       rx_hold;
    logic                rx_idle;
    logic                rx_empty;
    logic                rd_pop;
    logic [FC_RXT_W-1:0] rx_thr;
    logic [STATUS_W-1:0] status_w;
    logic [DW-1:0]       reg_view [NUM_REGS];

    serial_csr_decode #(.AW(AW), .NREG(NUM_REGS)) u_dec (
        .addr   (bus_addr),
        .rd_en  (bus_re),
        .wr_en  (bus_we),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    assign rx_thr = fc_q[FC_RXT_LO-FC_KEEP_LO +: FC_RXT_W];

    // Event vector feeding the interrupt core
    always_comb begin
        irq_events               = '0;
        irq_events[IRQ_TX_WMARK] = ev_tx_wmark;
        irq_events[IRQ_RX_WMARK] = rx_valid && (32'(rx_count) > 32'(rx_thr));
        irq_events[IRQ_TX_EMPTY] = ev_tx_empty;
        irq_events[IRQ_RX_OVF]   = ev_rx_ovf;
    end

    serial_csr_irq #(.N(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (wr_sel[IDX_ISTATE]),
        .en_we    (wr_sel[IDX_IEN]),
        .test_we  (wr_sel[IDX_ITEST]),
        .wmask    (bus_wdata[NUM_IRQ-1:0]),
        .events   (irq_events),
        .state_q  (irq_state),
        .enable_q (irq_en),
        .irq      (irq_vec)
    );

    assign rd_pop = rd_sel[IDX_RDATA] && ctrl_q[CTRL_RX_EN_BIT];

    serial_csr_rx #(.BW(BW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rd_pop     (rd_pop),
        .byte_q     (rx_hold),
        .rx_idle_q  (rx_idle),
        .rx_empty_q (rx_empty)
    );

    // Writable storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ovrd_q <= '0;
            tmo_q  <= '0;
            fc_q   <= '0;
        end else begin
            if (wr_sel[IDX_CTRL])  ctrl_q <= bus_wdata;
            if (wr_sel[IDX_OVRD])  ovrd_q <= bus_wdata;
            if (wr_sel[IDX_TMO])   tmo_q  <= bus_wdata;
            if (wr_sel[IDX_FCTRL]) fc_q   <= bus_wdata[FC_KEEP_HI:FC_KEEP_LO];
        end
    end

    // Transmit drained flag: a push clears it, an empty event sets it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_drained_q <= 1'b1;
        end else if (wr_sel[IDX_WDATA]) begin
            tx_drained_q <= 1'b0;
        end else if (ev_tx_empty) begin
            tx_drained_q <= 1'b1;
        end
    end

    // Push and flush pulses towards the transmit queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_push_q  <= 1'b0;
            tx_byte_q  <= '0;
            tx_flush_q <= 1'b0;
        end else begin
            tx_push_q  <= wr_sel[IDX_WDATA];
            tx_flush_q <= wr_sel[IDX_FCTRL] && bus_wdata[FC_TX_FLUSH_BIT];
            if (wr_sel[IDX_WDATA]) tx_byte_q <= bus_wdata[BW-1:0];
        end
    end

    // Status word assembly
    always_comb begin
        status_w              = '0;
        status_w[ST_TX_FULL]  = 1'b0;
        status_w[ST_RX_FULL]  = 1'b0;
        status_w[ST_TX_EMPTY] = tx_drained_q;
        status_w[ST_TX_IDLE]  = tx_drained_q;
        status_w[ST_RX_IDLE]  = rx_idle;
        status_w[ST_RX_EMPTY] = rx_empty;
    end

    // Readable view of every word index
    always_comb begin
        reg_view[IDX_CTRL]    = ctrl_q;
        reg_view[IDX_STATUS]  = DW'(status_w);
        reg_view[IDX_RDATA]   = DW'(rx_hold);
        reg_view[IDX_WDATA]   = '0;
        reg_view[IDX_ISTATE]  = DW'(irq_state);
        reg_view[IDX_IEN]     = DW'(irq_en);
        reg_view[IDX_ITEST]   = '0;
        reg_view[IDX_FCTRL]   = DW'({fc_q, {FC_KEEP_LO{1'b0}}});
        reg_view[IDX_FSTAT]   = DW'(rx_count);
        reg_view[IDX_OVRD]    = ovrd_q;
        reg_view[IDX_LINEVAL] = '0;
        reg_view[IDX_TMO]     = tmo_q;
    end

    // One-hot read multiplexer
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_sel[i]) rd_mux = rd_mux | reg_view[i];
        end
    end

    // Registered read data, zero after a cycle without a read
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_mux;
    end

    assign bus_rdata    = rdata_q;
    assign tx_push      = tx_push_q;
    assign tx_byte      = tx_byte_q;
    assign tx_flush     = tx_flush_q;
    assign irq_tx_wmark = irq_vec[IRQ_TX_WMARK];
    assign irq_rx_wmark = irq_vec[IRQ_RX_WMARK];
    assign irq_tx_empty = irq_vec[IRQ_TX_EMPTY];
    assign irq_rx_ovf   = irq_vec[IRQ_RX_OVF];
endmodule

// File: rtl/serial_csr_chk.sv
// Protocol checker for serial_csr, attached by bind. Observes ports and the
// interrupt enable of the receive-overflow source.
module serial_csr_chk
    import serial_csr_pkg::*;
#(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 32,
    parameter int unsigned BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_re,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [BW-1:0] wr_byte,
    input logic [DW-1:0] bus_rdata,
    input logic          tx_push,
    input logic [BW-1:0] tx_byte,
    input logic          tx_flush,
    input logic          ev_rx_ovf,
    input logic          irq_rx_ovf,
    input logic          ovf_en
);
    localparam logic [AW-1:0] A_WDATA = AW'(IDX_WDATA * 4);
    localparam logic [AW-1:0] A_FCTRL = AW'(IDX_FCTRL * 4);
    localparam logic [AW-1:0] A_IEN   = AW'(IDX_IEN * 4);

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));  // R12

    AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (bus_addr[1:0] != 2'b00)) |=> (bus_rdata == '0));  // R9

    AST_PUSH_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == A_WDATA)) |=> (tx_push && (tx_byte == $past(wr_byte))));  // R10

    AST_PUSH_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(bus_we && (bus_addr == A_WDATA)));  // R10

    AST_FLUSH_ONLY_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |-> $past(bus_we && (bus_addr == A_FCTRL) && wr_byte[FC_TX_FLUSH_BIT]));  // R13

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ovf && ovf_en && !(bus_we && (bus_addr == A_IEN))) |=> irq_rx_ovf);  // R11
endmodule

bind serial_csr serial_csr_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_re     (bus_re),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wr_byte    (bus_wdata[BW-1:0]),
    .bus_rdata  (bus_rdata),
    .tx_push    (tx_push),
    .tx_byte    (tx_byte),
    .tx_flush   (tx_flush),
    .ev_rx_ovf  (ev_rx_ovf),
    .irq_rx_ovf (irq_rx_ovf),
    .ovf_en     (irq_en[IRQ_RX_OVF])
);

// File: tb/serial_csr_bench.sv
// Self-checking bench for serial_csr: directed corner cases then seeded
// random traffic, compared against a cycle model kept in the bench.
module serial_csr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk;
    logic        rst_n;
    logic        bus_re, bus_we;
    logic [9:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        ev_tx_wmark, ev_tx_empty, ev_rx_ovf;
    logic        rx_valid;
    logic [7:0]  rx_byte;
    logic [4:0]  rx_count;
    logic        tx_push, tx_flush;
    logic [7:0]  tx_byte;
    logic        irq_tx_wmark, irq_rx_wmark, irq_tx_empty, irq_rx_ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model state
    logic [31:0] m_ctrl, m_ovrd, m_tmo;
    logic [4:0]  m_fc;
    logic [3:0]  m_st, m_en;
    logic [7:0]  m_rbyte, m_tbyte;
    logic        m_rxidle, m_rxempty, m_txdr;
    logic        m_push, m_flush;

    serial_csr u_serial_csr (
        .clk(clk), .rst_n(rst_n),
        .bus_re(bus_re), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tx_wmark(ev_tx_wmark), .ev_tx_empty(ev_tx_empty), .ev_rx_ovf(ev_rx_ovf),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_count(rx_count),
        .tx_push(tx_push), .tx_byte(tx_byte), .tx_flush(tx_flush),
        .irq_tx_wmark(irq_tx_wmark), .irq_rx_wmark(irq_rx_wmark),
        .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ctrl = '0; m_ovrd = '0; m_tmo = '0; m_fc = '0;
        m_st = '0; m_en = '0; m_rbyte = '0; m_tbyte = '0;
        m_rxidle = 1'b1; m_rxempty = 1'b1; m_txdr = 1'b1;
        m_push = 1'b0; m_flush = 1'b0;
    endtask

    function automatic logic [31:0] model_read(input logic [9:0] a, input logic [4:0] rc);
        if (a[1:0] != 2'b00) return '0;
        case (a[9:2])
            8'd0:  return m_ctrl;
            8'd1:  return {26'd0, m_rxempty, m_rxidle, m_txdr, m_txdr, 2'b00};
            8'd2:  return {24'd0, m_rbyte};
            8'd4:  return {28'd0, m_st};
            8'd5:  return {28'd0, m_en};
            8'd7:  return {25'd0, m_fc, 2'b00};
            8'd8:  return {27'd0, rc};
            8'd9:  return m_ovrd;
            8'd11: return m_tmo;
            default: return '0;
        endcase
    endfunction

    // One bus cycle: drive at falling edge, advance model at rising edge,
    // compare all outputs at the next falling edge.
    task automatic step(input logic re, input logic we, input logic [9:0] a,
                        input logic [31:0] d, input logic [2:0] ev,
                        input logic rv, input logic [7:0] rb, input logic [4:0] rc,
                        input string tag);
        logic [31:0] exp_rd;
        logic        al;
        logic [7:0]  ix;
        logic [3:0]  evv;
        bus_re = re; bus_we = we; bus_addr = a; bus_wdata = d;
        ev_tx_wmark = ev[0]; ev_tx_empty = ev[1]; ev_rx_ovf = ev[2];
        rx_valid = rv; rx_byte = rb; rx_count = rc;
        exp_rd = re ? model_read(a, rc) : 32'd0;
        al = (a[1:0] == 2'b00);
        ix = a[9:2];
        @(posedge clk);
        evv = {ev[2], ev[1], rv && (rc > {2'b00, m_fc[2:0]}), ev[0]};
        if (we && al && ix == 8'd4) m_st = m_st & ~d[3:0];
        if (we && al && ix == 8'd6) m_st = m_st | d[3:0];
        m_st = m_st | evv;
        if (we && al && ix == 8'd5) m_en = d[3:0];
        if (rv) begin
            m_rbyte = rb; m_rxidle = 1'b0; m_rxempty = 1'b0;
        end else if (re && al && ix == 8'd2 && m_ctrl[1]) begin
            m_rxidle = 1'b1; m_rxempty = 1'b1;
        end
        if (we && al && ix == 8'd3) m_txdr = 1'b0;
        else if (ev[1]) m_txdr = 1'b1;
        m_push  = we && al && ix == 8'd3;
        if (m_push) m_tbyte = d[7:0];
        m_flush = we && al && ix == 8'd7 && d[1];
        if (we && al && ix == 8'd0)  m_ctrl = d;
        if (we && al && ix == 8'd9)  m_ovrd = d;
        if (we && al && ix == 8'd11) m_tmo = d;
        if (we && al && ix == 8'd7)  m_fc = d[6:2];
        @(negedge clk);
        chk(re ? tag : "R12", bus_rdata, exp_rd);
        chk("R1", {28'd0, irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark}, {28'd0, m_st & m_en});
        chk("R10", {23'd0, tx_push, tx_byte}, {23'd0, m_push, m_tbyte});
        chk("R13", {31'd0, tx_flush}, {31'd0, m_flush});
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input string tag);
        step(1'b0, 1'b1, a, d, 3'b000, 1'b0, 8'h00, 5'd0, tag);
    endtask

    task automatic rd(input logic [9:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'd0, 3'b000, 1'b0, 8'h00, 5'd0, tag);
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h5EED_0C5A;
        void'($urandom(seed));
        rst_n = 1'b0;
        bus_re = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        ev_tx_wmark = 0; ev_tx_empty = 0; ev_rx_ovf = 0;
        rx_valid = 0; rx_byte = '0; rx_count = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset values of every index and idle outputs
        for (int i = 0; i < 12; i++) rd(10'(i * 4), "R4");

        // R14: storage registers
        wr(10'h000, 32'hA5A5_0002, "R14");
        wr(10'h024, 32'h1357_9BDF, "R14");
        wr(10'h02C, 32'hFEDC_BA98, "R14");
        rd(10'h000, "R14"); rd(10'h024, "R14"); rd(10'h02C, "R14");

        // R8: read-only and write-only registers
        wr(10'h004, 32'hFFFF_FFFF, "R8");
        wr(10'h008, 32'hFFFF_FFFF, "R8");
        wr(10'h020, 32'hFFFF_FFFF, "R8");
        wr(10'h028, 32'hFFFF_FFFF, "R8");
        rd(10'h004, "R8"); rd(10'h008, "R8"); rd(10'h028, "R8"); rd(10'h00C, "R8");
        step(1'b1, 1'b0, 10'h020, 32'd0, 3'b000, 1'b0, 8'h00, 5'd19, "R8");

        // R9: misaligned and unmapped accesses
        wr(10'h001, 32'h0000_0000, "R9");
        rd(10'h000, "R9");
        rd(10'h030, "R9"); rd(10'h3FC, "R9"); rd(10'h012, "R9");

        // R3 and R1: test register sets state, reads zero
        wr(10'h014, 32'h0000_000F, "R1");
        wr(10'h018, 32'h0000_0005, "R3");
        rd(10'h018, "R3"); rd(10'h010, "R3");

        // R2: write-one-to-clear
        wr(10'h010, 32'h0000_0001, "R2");
        rd(10'h010, "R2");

        // R11: event wins over a clear of the same bit
        step(1'b0, 1'b1, 10'h010, 32'h0000_000F, 3'b100, 1'b0, 8'h00, 5'd0, "R11");
        rd(10'h010, "R11");
        wr(10'h010, 32'h0000_000F, "R2");

        // R6: receive threshold boundary (threshold 2)
        wr(10'h01C, 32'h0000_0008, "R6");
        step(1'b0, 1'b0, 10'h000, 32'd0, 3'b000, 1'b1, 8'h3C, 5'd2, "R6");
        rd(10'h010, "R6");
        step(1'b0, 1'b0, 10'h000, 32'd0, 3'b000, 1'b1, 8'h7E, 5'd3, "R6");
        rd(10'h010, "R6");

        // R5 and R7: byte latch, status clear, consuming read with receive enabled
        rd(10'h004, "R5");
        rd(10'h008, "R5");
        rd(10'h004, "R7");
        // R7: receive disabled leaves status
        wr(10'h000, 32'h0000_0000, "R7");
        step(1'b0, 1'b0, 10'h000, 32'd0, 3'b000, 1'b1, 8'hC1, 5'd0, "R7");
        rd(10'h008, "R7");
        rd(10'h004, "R7");
        // R7: byte strobe coincident with a consuming read wins
        wr(10'h000, 32'h0000_0002, "R7");
        step(1'b1, 1'b0, 10'h008, 32'd0, 3'b000, 1'b1, 8'h5A, 5'd0, "R7");
        rd(10'h004, "R7");

        // R10: push pulse, transmit status, empty event, write beats event
        wr(10'h00C, 32'h1234_56C3, "R10");
        rd(10'h004, "R10");
        step(1'b0, 1'b0, 10'h000, 32'd0, 3'b010, 1'b0, 8'h00, 5'd0, "R10");
        rd(10'h004, "R10");
        step(1'b0, 1'b1, 10'h00C, 32'h0000_0099, 3'b010, 1'b0, 8'h00, 5'd0, "R10");
        rd(10'h004, "R10");

        // R13: flush pulse and queue-control readback
        wr(10'h01C, 32'h0000_007B, "R13");
        rd(10'h01C, "R13");

        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [9:0]  a;
            logic [31:0] d;
            logic [2:0]  ev;
            logic        re, we, rv;
            a = 10'(($urandom % 14) * 4);
            if (($urandom % 8) == 0) a = a | 10'($urandom % 4);
            if (($urandom % 16) == 0) a = 10'($urandom);
            d  = $urandom;
            re = ($urandom % 2) == 0;
            we = ($urandom % 3) == 0;
            ev = 3'($urandom % 8) & 3'($urandom % 8);
            rv = ($urandom % 4) == 0;
            step(re, we, a, d, ev, rv, 8'($urandom), 5'($urandom), "R12");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule